// File: doc/BRIEF.md
# Read Transaction Reconstructor

This block sits beside the read half of an AXI interface and watches the read-address and read-data channels without driving any of their signals. Every read address accepted on the bus opens a context in a small per-ID queue. The read-data beats that follow are steered into the oldest open context of their ID. Beats from different IDs may interleave freely, while beats of one ID belong to its reads in issue order. When the beat carrying the last flag arrives, the context is closed. One summary record is then presented on a valid/ready output for a scoreboard or coverage collector.

A record carries the ID, the address parameters of the read, the number of beats actually observed, the most severe response seen on any beat, an order-sensitive checksum of the data and a flag for a burst whose observed length disagrees with its requested length. Protocol anomalies the reconstructor cannot place, such as a beat with no open read or an address that finds its queue full, raise a sticky error output. Whole payloads are not stored.

Top module: `rtr_read_recon`

## Requirements
- R1: An address or data beat is taken only in a cycle where that channel's valid and ready inputs are both high; a beat offered with ready low changes no record and no error.
- R2: Each taken address beat opens a context for its ID, and the record for that read reports the same ID, address, length, size and burst values.
- R3: A data beat updates only a context of its own ID, so beats of different IDs may interleave. The checksum starts at zero and, for each beat in arrival order, becomes the old value rotated left by one bit, XOR the beat data.
- R4: Reads of one ID are filled and reported in the order their addresses were taken; a data beat always goes to the oldest read of its ID that has not yet seen its last beat.
- R5: A beat with the last flag set completes its read; the record's beat count equals the number of beats taken for that read, and the context is freed once the record has been handed over.
- R6: Response codes are 00 OKAY, 01 EXOKAY, 10 SLVERR, 11 DECERR; the record reports the most severe response over all its beats, with DECERR above SLVERR above EXOKAY above OKAY.
- R7: The record's length-error bit is 1 exactly when the observed beat count differs from the requested length plus one.
- R8: The error output goes to 1 and stays there until reset when a data beat is taken for an ID with no read awaiting data, or an address beat is taken for an ID whose queue already holds 4 reads (completed records not yet handed over included); that address is dropped.
- R9: A completed read is presented in the cycle after the edge that closed it, if the output is free. Records leave one at a time, and the lowest ID with a completed read goes first. While rec_valid is high and rec_ready is low, the record stays unchanged.
- R10: After reset, rec_valid and proto_err are 0 and every queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ar_valid | input | 1 | Observed read-address valid |
| ar_ready | input | 1 | Observed read-address ready |
| ar_id | input | ID_W | Observed read-address ID |
| ar_addr | input | ADDR_W | Observed start address |
| ar_len | input | LEN_W | Observed burst length minus one |
| ar_size | input | 3 | Observed beat size code |
| ar_burst | input | 2 | Observed burst type |
| r_valid | input | 1 | Observed read-data valid |
| r_ready | input | 1 | Observed read-data ready |
| r_id | input | ID_W | Observed read-data ID |
| r_data | input | DATA_W | Observed read data |
| r_resp | input | 2 | Observed per-beat response |
| r_last | input | 1 | Observed last-beat flag |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Record consumer ready |
| rec_id | output | ID_W | Record ID |
| rec_addr | output | ADDR_W | Record start address |
| rec_len | output | LEN_W | Record requested length minus one |
| rec_size | output | 3 | Record beat size code |
| rec_burst | output | 2 | Record burst type |
| rec_beats | output | LEN_W+1 | Beats observed for the read |
| rec_resp | output | 2 | Most severe response of the read |
| rec_csum | output | DATA_W | Rotate-XOR checksum of the data |
| rec_len_err | output | 1 | Observed length differs from requested |
| proto_err | output | 1 | Sticky protocol anomaly flag |

## Verification
A queue pointer or counter that drifts shows up at the ports on the next record for that ID. The record carries a wrong address or checksum when a beat lands in the wrong entry. A completion counter that drifts gives a record too early, too late or never, or a spurious error flag the first time that ID is used again. A wrong choice between IDs shows up as a swapped record order in the first cycle that two IDs have completions pending. A faulty output register shows as a changed payload during a stall. The reference model predicts every output on every clock, so any such fault is caught within a cycle of reaching the ports.

// File: rtl/rtr_pkg.sv
package rtr_pkg;

    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int LEN_W   = 8;
    localparam int SIZE_W  = 3;
    localparam int BURST_W = 2;

    // Encoding order matches severity order, so "worse" is "numerically larger".
    typedef enum logic [1:0] {
        RSP_OKAY   = 2'b00,
        RSP_EXOKAY = 2'b01,
        RSP_SLVERR = 2'b10,
        RSP_DECERR = 2'b11
    } resp_e;

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        logic [LEN_W-1:0]   len;
        logic [SIZE_W-1:0]  size;
        logic [BURST_W-1:0] burst;
        logic [LEN_W:0]     beats;
        resp_e              resp;
        logic [DATA_W-1:0]  csum;
        logic               len_err;
    } rd_ctx_t;

    function automatic resp_e resp_max(resp_e a, resp_e b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [DATA_W-1:0] csum_step(logic [DATA_W-1:0] c,
                                                    logic [DATA_W-1:0] d);
        return {c[DATA_W-2:0], c[DATA_W-1]} ^ d;
    endfunction

    function automatic rd_ctx_t ctx_open(logic [ADDR_W-1:0]  addr,
                                         logic [LEN_W-1:0]   len,
                                         logic [SIZE_W-1:0]  size,
                                         logic [BURST_W-1:0] burst);
        rd_ctx_t c;
        c         = '0;
        c.addr    = addr;
        c.len     = len;
        c.size    = size;
        c.burst   = burst;
        c.resp    = RSP_OKAY;
        return c;
    endfunction

    function automatic rd_ctx_t ctx_fold(rd_ctx_t c, logic [DATA_W-1:0] d,
                                         resp_e r, logic last);
        rd_ctx_t n;
        n       = c;
        n.beats = c.beats + (LEN_W+1)'(1);
        n.resp  = resp_max(c.resp, r);
        n.csum  = csum_step(c.csum, d);
        if (last) begin
            n.len_err = (n.beats != ({1'b0, c.len} + (LEN_W+1)'(1)));
        end
        return n;
    endfunction

endpackage

// File: rtl/rtr_id_queue.sv
module rtr_id_queue
    import rtr_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  rd_ctx_t           push_ctx,
    input  logic              beat,
    input  logic [DATA_W-1:0] beat_data,
    input  resp_e             beat_resp,
    input  logic              beat_last,
    input  logic              pop,
    output logic              full,
    output logic              has_open,
    output logic              has_done,
    output rd_ctx_t           head_ctx
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    rd_ctx_t         mem [DEPTH];
    logic [PW-1:0]   rd_ptr;
    logic [PW-1:0]   act_ptr;
    logic [PW-1:0]   wr_ptr;
    logic [CW-1:0]   n_total;
    logic [CW-1:0]   n_done;
    logic            do_push;
    logic            do_beat;
    logic            do_close;

    // Entries [rd_ptr, act_ptr) are complete, [act_ptr, wr_ptr) await data.
    assign act_ptr  = rd_ptr + PW'(n_done);
    assign wr_ptr   = rd_ptr + PW'(n_total);
    assign full     = (n_total == CW'(DEPTH));
    assign has_open = (n_total != n_done);
    assign has_done = (n_done != '0);
    assign head_ctx = mem[rd_ptr];

    assign do_push  = push & ~full;
    assign do_beat  = beat & has_open;
    assign do_close = do_beat & beat_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr  <= '0;
            n_total <= '0;
            n_done  <= '0;
        end else begin
            rd_ptr  <= rd_ptr + PW'(pop);
            n_total <= n_total + CW'(do_push) - CW'(pop);
            n_done  <= n_done + CW'(do_close) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_ctx;
        end
        if (do_beat) begin
            mem[act_ptr] <= ctx_fold(mem[act_ptr], beat_data, beat_resp, beat_last);
        end
    end

endmodule

// File: rtl/rtr_pick.sv
module rtr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    // Fixed priority: the lowest requesting index wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/rtr_read_recon.sv
module rtr_read_recon
    import rtr_pkg::*;
#(
    parameter int ID_W   = 2,
    parameter int QDEPTH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ar_valid,
    input  logic               ar_ready,
    input  logic [ID_W-1:0]    ar_id,
    input  logic [ADDR_W-1:0]  ar_addr,
    input  logic [LEN_W-1:0]   ar_len,
    input  logic [SIZE_W-1:0]  ar_size,
    input  logic [BURST_W-1:0] ar_burst,
    input  logic               r_valid,
    input  logic               r_ready,
    input  logic [ID_W-1:0]    r_id,
    input  logic [DATA_W-1:0]  r_data,
    input  logic [1:0]         r_resp,
    input  logic               r_last,
    output logic               rec_valid,
    input  logic               rec_ready,
    output logic [ID_W-1:0]    rec_id,
    output logic [ADDR_W-1:0]  rec_addr,
    output logic [LEN_W-1:0]   rec_len,
    output logic [SIZE_W-1:0]  rec_size,
    output logic [BURST_W-1:0] rec_burst,
    output logic [LEN_W:0]     rec_beats,
    output logic [1:0]         rec_resp,
    output logic [DATA_W-1:0]  rec_csum,
    output logic               rec_len_err,
    output logic               proto_err
);

    localparam int NUM_IDS = 1 << ID_W;

    logic                ar_fire;
    logic                r_fire;
    rd_ctx_t             ar_ctx;
    logic [NUM_IDS-1:0]  full_vec;
    logic [NUM_IDS-1:0]  open_vec;
    logic [NUM_IDS-1:0]  done_vec;
    logic [NUM_IDS-1:0]  pop_vec;
    rd_ctx_t             head_ctx [NUM_IDS];
    logic                pick_any;
    logic [ID_W-1:0]     pick_idx;
    logic                load;
    logic                err_set;
    logic                out_v;
    logic [ID_W-1:0]     out_id;
    rd_ctx_t             out_ctx;
    logic                err_q;

    assign ar_fire = ar_valid & ar_ready;
    assign r_fire  = r_valid & r_ready;
    assign ar_ctx  = ctx_open(ar_addr, ar_len, ar_size, ar_burst);

    for (genvar g = 0; g < NUM_IDS; g++) begin : g_slot
        rtr_id_queue #(.DEPTH(QDEPTH)) u_q (
            .clk       (clk),
            .rst       (rst),
            .push      (ar_fire && (ar_id == ID_W'(g))),
            .push_ctx  (ar_ctx),
            .beat      (r_fire && (r_id == ID_W'(g))),
            .beat_data (r_data),
            .beat_resp (resp_e'(r_resp)),
            .beat_last (r_last),
            .pop       (pop_vec[g]),
            .full      (full_vec[g]),
            .has_open  (open_vec[g]),
            .has_done  (done_vec[g]),
            .head_ctx  (head_ctx[g])
        );
    end

    rtr_pick #(.N(NUM_IDS), .IW(ID_W)) u_pick (
        .req (done_vec),
        .any (pick_any),
        .idx (pick_idx)
    );

    assign load    = pick_any & (~out_v | rec_ready);
    assign pop_vec = load ? (NUM_IDS'(1) << pick_idx) : '0;
    assign err_set = (ar_fire & full_vec[ar_id]) | (r_fire & ~open_vec[r_id]);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_v   <= 1'b0;
            out_id  <= '0;
            out_ctx <= '0;
            err_q   <= 1'b0;
        end else begin
            if (load) begin
                out_v   <= 1'b1;
                out_id  <= pick_idx;
                out_ctx <= head_ctx[pick_idx];
            end else if (rec_ready) begin
                out_v   <= 1'b0;
            end
            if (err_set) begin
                err_q <= 1'b1;
            end
        end
    end

    assign rec_valid   = out_v;
    assign rec_id      = out_id;
    assign rec_addr    = out_ctx.addr;
    assign rec_len     = out_ctx.len;
    assign rec_size    = out_ctx.size;
    assign rec_burst   = out_ctx.burst;
    assign rec_beats   = out_ctx.beats;
    assign rec_resp    = out_ctx.resp;
    assign rec_csum    = out_ctx.csum;
    assign rec_len_err = out_ctx.len_err;
    assign proto_err   = err_q;

endmodule

// File: rtl/rtr_read_recon_chk.sv
module rtr_read_recon_chk
    import rtr_pkg::*;
#(
    parameter int ID_W    = 2,
    parameter int NUM_IDS = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               ar_fire,
    input logic [ID_W-1:0]    ar_id,
    input logic               r_fire,
    input logic [ID_W-1:0]    r_id,
    input logic [NUM_IDS-1:0] open_vec,
    input logic [NUM_IDS-1:0] full_vec,
    input logic               rec_valid,
    input logic               rec_ready,
    input logic [ID_W-1:0]    rec_id,
    input logic [ADDR_W-1:0]  rec_addr,
    input logic [LEN_W-1:0]   rec_len,
    input logic [LEN_W:0]     rec_beats,
    input logic [1:0]         rec_resp,
    input logic [DATA_W-1:0]  rec_csum,
    input logic               rec_len_err,
    input logic               proto_err
);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        rec_valid && !rec_ready |=> rec_valid && $stable(rec_id) && $stable(rec_addr)
            && $stable(rec_len) && $stable(rec_beats) && $stable(rec_resp)
            && $stable(rec_csum) && $stable(rec_len_err));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    assert_orphan_beat_R8: assert property (@(posedge clk) disable iff (rst)
        r_fire && !open_vec[r_id] |=> proto_err);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        ar_fire && full_vec[ar_id] |=> proto_err);

    assert_nonempty_R5: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> rec_beats != '0);

    assert_len_flag_R7: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> rec_len_err == (rec_beats != ({1'b0, rec_len} + (LEN_W+1)'(1))));

    assert_reset_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rec_valid && !proto_err);

endmodule

bind rtr_read_recon rtr_read_recon_chk #(.ID_W(ID_W), .NUM_IDS(NUM_IDS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ar_fire     (ar_fire),
    .ar_id       (ar_id),
    .r_fire      (r_fire),
    .r_id        (r_id),
    .open_vec    (open_vec),
    .full_vec    (full_vec),
    .rec_valid   (rec_valid),
    .rec_ready   (rec_ready),
    .rec_id      (rec_id),
    .rec_addr    (rec_addr),
    .rec_len     (rec_len),
    .rec_beats   (rec_beats),
    .rec_resp    (rec_resp),
    .rec_csum    (rec_csum),
    .rec_len_err (rec_len_err),
    .proto_err   (proto_err)
);

// File: tb/test_rtr_read_recon.sv
module test_rtr_read_recon;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic        ar_valid, ar_ready;
    logic [1:0]  ar_id;
    logic [31:0] ar_addr;
    logic [7:0]  ar_len;
    logic [2:0]  ar_size;
    logic [1:0]  ar_burst;
    logic        r_valid, r_ready;
    logic [1:0]  r_id;
    logic [31:0] r_data;
    logic [1:0]  r_resp;
    logic        r_last;
    logic        rec_valid, rec_ready;
    logic [1:0]  rec_id;
    logic [31:0] rec_addr;
    logic [7:0]  rec_len;
    logic [2:0]  rec_size;
    logic [1:0]  rec_burst;
    logic [8:0]  rec_beats;
    logic [1:0]  rec_resp;
    logic [31:0] rec_csum;
    logic        rec_len_err;
    logic        proto_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtr_read_recon i_rtr_read_recon (.*);

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit cmp_on   = 1'b0;
    bit finished = 1'b0;

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct {
        logic [31:0] addr;
        logic [7:0]  len;
        logic [2:0]  size;
        logic [1:0]  burst;
        int          beats;
        logic [1:0]  resp;
        logic [31:0] csum;
        bit          len_err;
        bit          done;
    } ment_t;

    ment_t mq [4][$];
    bit    mv;
    ment_t mo;
    int    mo_id;
    bit    merr;

    always @(posedge clk) begin
        int    sel;
        int    k;
        bit    ld;
        ment_t t;
        cycles++;
        if (rst) begin
            for (int i = 0; i < 4; i++) mq[i].delete();
            mv   = 1'b0;
            merr = 1'b0;
        end else begin
            sel = -1;
            for (int i = 0; i < 4; i++)
                if (sel < 0 && mq[i].size() > 0 && mq[i][0].done) sel = i;
            ld = (sel >= 0) && (!mv || rec_ready);
            if (r_valid && r_ready) begin
                k = -1;
                for (int j = 0; j < mq[r_id].size(); j++)
                    if (k < 0 && !mq[r_id][j].done) k = j;
                if (k < 0) merr = 1'b1;
                else begin
                    t = mq[r_id][k];
                    t.beats++;
                    if (r_resp > t.resp) t.resp = r_resp;
                    t.csum = ((t.csum << 1) | (t.csum >> 31)) ^ r_data;
                    if (r_last) begin
                        t.done    = 1'b1;
                        t.len_err = (t.beats != int'(t.len) + 1);
                    end
                    mq[r_id][k] = t;
                end
            end
            if (ar_valid && ar_ready) begin
                if (mq[ar_id].size() >= 4) merr = 1'b1;
                else begin
                    t = '{addr: ar_addr, len: ar_len, size: ar_size, burst: ar_burst,
                          beats: 0, resp: 2'b00, csum: 32'h0, len_err: 1'b0, done: 1'b0};
                    mq[ar_id].push_back(t);
                end
            end
            if (ld) begin
                mo    = mq[sel][0];
                mo_id = sel;
                void'(mq[sel].pop_front());
                mv = 1'b1;
            end else if (rec_ready) begin
                mv = 1'b0;
            end
        end
    end

    // Compare away from the active edge, every cycle.
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            chk(rec_valid === mv, "R9", "rec_valid", 64'(rec_valid), 64'(mv));
            chk(proto_err === merr, "R8", "proto_err", 64'(proto_err), 64'(merr));
            if (mv) begin
                chk(rec_id === 2'(mo_id), "R2", "rec_id", 64'(rec_id), 64'(mo_id));
                chk(rec_addr === mo.addr, "R4", "rec_addr", 64'(rec_addr), 64'(mo.addr));
                chk({rec_len, rec_size, rec_burst} === {mo.len, mo.size, mo.burst}, "R2",
                    "len/size/burst", 64'({rec_len, rec_size, rec_burst}),
                    64'({mo.len, mo.size, mo.burst}));
                chk(rec_beats === 9'(mo.beats), "R5", "rec_beats", 64'(rec_beats), 64'(mo.beats));
                chk(rec_resp === mo.resp, "R6", "rec_resp", 64'(rec_resp), 64'(mo.resp));
                chk(rec_csum === mo.csum, "R3", "rec_csum", 64'(rec_csum), 64'(mo.csum));
                chk(rec_len_err === mo.len_err, "R7", "rec_len_err", 64'(rec_len_err),
                    64'(mo.len_err));
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(bit av, bit ardy, logic [1:0] aid, logic [31:0] aaddr, logic [7:0] alen,
                        bit rv, bit rrdy, logic [1:0] rid, logic [31:0] rdat, logic [1:0] rrsp,
                        bit rlst);
        @(negedge clk);
        ar_valid = av;  ar_ready = ardy; ar_id = aid; ar_addr = aaddr; ar_len = alen;
        ar_size  = 3'd2; ar_burst = 2'b01;
        r_valid  = rv;  r_ready = rrdy; r_id = rid; r_data = rdat; r_resp = rrsp; r_last = rlst;
    endtask

    task automatic ar(logic [1:0] id, logic [31:0] a, logic [7:0] l);
        step(1, 1, id, a, l, 0, 1, 0, 0, 0, 0);
    endtask

    task automatic rb(logic [1:0] id, logic [31:0] d, logic [1:0] rs, bit lst);
        step(0, 1, 0, 0, 0, 1, 1, id, d, rs, lst);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > WD_LIMIT && !finished) begin
            failures++;
            $display("FAIL R9 watchdog: actual=%0d expected<=%0d", cycles, WD_LIMIT);
            finish_run();
        end
    end

    initial begin
        logic [1:0] held_id;
        logic [31:0] held_addr;
        rst = 1'b1; rec_ready = 1'b1;
        ar_valid = 0; ar_ready = 0; ar_id = 0; ar_addr = 0; ar_len = 0; ar_size = 0; ar_burst = 0;
        r_valid = 0; r_ready = 0; r_id = 0; r_data = 0; r_resp = 0; r_last = 0;
        repeat (3) @(negedge clk);
        chk(rec_valid === 1'b0, "R10", "rec_valid after reset", 64'(rec_valid), 0);
        chk(proto_err === 1'b0, "R10", "proto_err after reset", 64'(proto_err), 0);
        rst = 1'b0;
        cmp_on = 1'b1;

        // R1: offered beats without ready are not taken.
        step(1, 0, 2, 32'h0000_9000, 0, 0, 1, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0, 1, 0, 2, 32'h1234_5678, 2'b11, 1);
        idle(3);
        chk(proto_err === 1'b0, "R1", "stalled beats raised error", 64'(proto_err), 0);
        chk(rec_valid === 1'b0, "R1", "stalled beats made record", 64'(rec_valid), 0);

        // R2/R5: one plain burst of four beats.
        ar(1, 32'h0000_1000, 3);
        rb(1, 32'hA5A5_0001, 2'b00, 0);
        rb(1, 32'h8000_0002, 2'b00, 0);
        rb(1, 32'hFFFF_0003, 2'b00, 0);
        rb(1, 32'h0101_0004, 2'b00, 1);
        idle(3);

        // R3/R6: interleaved IDs, id 2 finishes first, mixed responses.
        ar(0, 32'h0000_2000, 2);
        ar(2, 32'h0000_3000, 1);
        rb(2, 32'h1111_0000, 2'b00, 0);
        rb(0, 32'h2222_0000, 2'b01, 0);
        step(1, 1, 3, 32'h0000_3800, 0, 1, 1, 2, 32'h3333_0000, 2'b10, 1);
        rb(0, 32'h4444_0000, 2'b11, 0);
        rb(3, 32'h5555_0000, 2'b01, 1);
        rb(0, 32'h6666_0000, 2'b00, 1);
        idle(4);

        // R4: two reads on one ID complete in issue order.
        ar(3, 32'h0000_4000, 1);
        ar(3, 32'h0000_5000, 0);
        rb(3, 32'h0F0F_0F0F, 2'b00, 0);
        rb(3, 32'hF0F0_F0F0, 2'b00, 1);
        rb(3, 32'hCAFE_0000, 2'b10, 1);
        idle(4);

        // R7: short and long bursts.
        ar(1, 32'h0000_6000, 2);
        rb(1, 32'h0000_0006, 2'b00, 1);
        ar(1, 32'h0000_7000, 0);
        rb(1, 32'h0000_0007, 2'b00, 0);
        rb(1, 32'h0000_0008, 2'b00, 1);
        idle(4);

        // R9: stalled output, several completions queued, lowest ID first.
        rec_ready = 1'b0;
        ar(3, 32'h0000_A300, 0);
        ar(1, 32'h0000_A100, 0);
        ar(0, 32'h0000_A000, 0);
        rb(3, 32'h0000_0033, 2'b00, 1);
        rb(1, 32'h0000_0011, 2'b00, 1);
        rb(0, 32'h0000_0000, 2'b00, 1);
        held_id = rec_id; held_addr = rec_addr;
        idle(3);
        chk(rec_id === held_id, "R9", "id changed during stall", 64'(rec_id), 64'(held_id));
        chk(rec_addr === held_addr, "R9", "addr changed during stall", 64'(rec_addr),
            64'(held_addr));
        chk(rec_id === 2'd3, "R9", "first record id", 64'(rec_id), 3);
        @(negedge clk); rec_ready = 1'b1;
        idle(6);

        // R8: fifth outstanding read on one ID is dropped and flagged.
        ar(2, 32'h0000_B000, 0);
        ar(2, 32'h0000_B100, 0);
        ar(2, 32'h0000_B200, 0);
        ar(2, 32'h0000_B300, 0);
        ar(2, 32'h0000_B400, 0);
        idle(1);
        chk(proto_err === 1'b1, "R8", "overflow flag", 64'(proto_err), 1);
        for (int i = 0; i < 5; i++) rb(2, 32'h0000_0B00 + 32'(i), 2'b00, 1);
        idle(8);

        // R10: reset clears the flag and queues; R8: orphan beat.
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        chk(proto_err === 1'b0, "R10", "flag after reset", 64'(proto_err), 0);
        chk(rec_valid === 1'b0, "R10", "valid after reset", 64'(rec_valid), 0);
        rb(0, 32'hDEAD_BEEF, 2'b00, 1);
        idle(1);
        chk(proto_err === 1'b1, "R8", "orphan beat flag", 64'(proto_err), 1);
        chk(rec_valid === 1'b0, "R8", "orphan beat made record", 64'(rec_valid), 0);
        idle(2);

        finish_run();
    end

endmodule